// File: doc/BRIEF.md
# Isochronous Endpoint Frame Scheduler

This block controls one isochronous endpoint of a USB device controller. Software primes the endpoint with a descriptor. The descriptor carries a two-bit count of transactions per frame. The block acknowledges the prime at once but does not arm the endpoint then. The endpoint arms only at the next start-of-frame (SOF) strobe. Once armed, the endpoint runs exactly the programmed number of transactions and then retires the descriptor.

A descriptor that does not finish in its frame stays armed. Its per-frame count restarts at each later SOF until it completes or software cancels it. No NAK handshake exists. An IN token to an endpoint that is not armed gets a zero-length packet. An OUT token to an endpoint that is not armed is dropped without a handshake.

The packet engine reports token arrivals and transaction completions. The block answers each token with a response code one cycle later.

Top module: `iso_ep_sched`

## Requirements
- R1: A prime request on an idle endpoint raises `epPending` on the next cycle and never raises `epArmed` directly. `epArmed` rises one cycle after the first SOF seen while pending, and `epPending` falls at the same time.
- R2: `primeAck` pulses for one cycle, one cycle after a prime request on an idle endpoint. It does not wait for the SOF.
- R3: An armed endpoint counts completed transactions in the current frame. It never completes more than the programmed count (1 to 3) in that frame.
- R4: One cycle after the done event that brings the count to the programmed value, `retire` pulses for one cycle and the endpoint returns to idle.
- R5: An IN token on an endpoint that is not armed is answered one cycle later with `respValid` and code 1 (zero-length packet).
- R6: An OUT token on an endpoint that is not armed gets code 3 (drop). A token on an armed endpoint with no transaction in progress gets code 2 (transfer) and starts a transaction. The code is 2 bits: 1 = zero-length packet, 2 = transfer, 3 = drop.
- R7: An SOF on an armed endpoint with no transaction in progress restarts the frame count at zero. The endpoint stays armed and no retire is produced.
- R8: A token that arrives while a transaction is in progress is answered with code 3 and does not add to the count.
- R9: A prime with a count of 0 pulses `primeAck` together with `multErr` and leaves the endpoint idle.
- R10: A cancel request returns the endpoint to idle on the next cycle. It produces no retire, even if a done event arrives in the same cycle.
- R11: An SOF that arrives during a transaction is held. When that transaction's done event arrives, the frame count restarts at zero instead of advancing, unless that done completes the descriptor.
- R12: A prime request while the endpoint is pending or armed is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| primeReq | input | 1 | Software prime strobe |
| primeMult | input | MULT_W | Transactions per frame carried by the descriptor |
| cancelReq | input | 1 | Software cancel strobe |
| sofStb | input | 1 | Start-of-frame strobe |
| tokValid | input | 1 | Token event from the packet engine |
| tokIsIn | input | 1 | 1 = IN token, 0 = OUT token |
| xferDone | input | 1 | Current transaction finished |
| primeAck | output | 1 | Descriptor accepted |
| multErr | output | 1 | Prime carried a zero count |
| retire | output | 1 | Descriptor completed |
| epPending | output | 1 | Primed, waiting for SOF |
| epArmed | output | 1 | Active in the frame schedule |
| respValid | output | 1 | Response code valid |
| respCode | output | 2 | 1 zero-length packet, 2 transfer, 3 drop |

## Verification
Several rules are checked by properties on every cycle:
- the idle state never jumps straight to armed;
- a retire comes only from the armed state;
- a cancel always leaves the endpoint idle with no retire;
- the frame count stays below the programmed count while armed.

Other behaviours need directed sequences against the bench's model:
- the restart of a frame that did not finish;
- an SOF held across a busy transaction;
- tokens that collide with a transaction in progress;
- the exact count of done events before retire.

// File: rtl/iso_sched_pkg.sv
package iso_sched_pkg;
  typedef enum logic [1:0] {EP_IDLE = 2'd0, EP_PEND = 2'd1, EP_ACT = 2'd2} epState_t;
  typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_ZLP = 2'd1, RSP_XFER = 2'd2, RSP_DROP = 2'd3} rspCode_t;
  typedef struct packed {
    logic     loadMult;
    logic     clrCount;
    logic     incCount;
    logic     rspLoad;
    rspCode_t rspCode;
  } dpCtrl_t;
endpackage

// File: rtl/iso_sched_ctrl.sv
module iso_sched_ctrl
  import iso_sched_pkg::*;
#(
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              primeReq,
  input  logic [MULT_W-1:0] primeMult,
  input  logic              cancelReq,
  input  logic              sofStb,
  input  logic              tokValid,
  input  logic              tokIsIn,
  input  logic              xferDone,
  input  logic              lastXfer,
  output dpCtrl_t           strobes,
  output logic              primeAck,
  output logic              multErr,
  output logic              retire,
  output logic              epPending,
  output logic              epArmed
);
  epState_t state, nState;
  logic busy, nBusy, sofLat, nSofLat, nAck, nErr, nRetire;

  always_comb begin
    nState  = state;
    nBusy   = busy;
    nSofLat = sofLat;
    nAck    = 1'b0;
    nErr    = 1'b0;
    nRetire = 1'b0;
    strobes = '0;
    if (cancelReq) begin
      nState  = EP_IDLE;
      nBusy   = 1'b0;
      nSofLat = 1'b0;
    end else begin
      case (state)
        EP_IDLE: if (primeReq) begin
          nAck = 1'b1;
          if (primeMult == '0) nErr = 1'b1;
          else begin
            nState = EP_PEND;
            strobes.loadMult = 1'b1;
          end
        end
        EP_PEND: if (sofStb) begin
          nState = EP_ACT;
          strobes.clrCount = 1'b1;
        end
        EP_ACT: begin
          if (busy) begin
            if (xferDone) begin
              nBusy = 1'b0;
              if (lastXfer) begin
                nRetire = 1'b1;
                nState  = EP_IDLE;
                nSofLat = 1'b0;
              end else if (sofLat || sofStb) begin
                strobes.clrCount = 1'b1;
                nSofLat = 1'b0;
              end else begin
                strobes.incCount = 1'b1;
              end
            end else if (sofStb) begin
              nSofLat = 1'b1;
            end
          end else begin
            if (sofStb) strobes.clrCount = 1'b1;
            if (tokValid) nBusy = 1'b1;
          end
        end
        default: nState = EP_IDLE;
      endcase
    end
    if (tokValid) begin
      strobes.rspLoad = 1'b1;
      if (state == EP_ACT && !cancelReq) strobes.rspCode = busy ? RSP_DROP : RSP_XFER;
      else strobes.rspCode = tokIsIn ? RSP_ZLP : RSP_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= EP_IDLE;
      busy     <= 1'b0;
      sofLat   <= 1'b0;
      primeAck <= 1'b0;
      multErr  <= 1'b0;
      retire   <= 1'b0;
    end else begin
      state    <= nState;
      busy     <= nBusy;
      sofLat   <= nSofLat;
      primeAck <= nAck;
      multErr  <= nErr;
      retire   <= nRetire;
    end
  end

  assign epPending = (state == EP_PEND);
  assign epArmed   = (state == EP_ACT);

  // R1: idle never goes straight to armed
  a_r1_no_direct_arm: assert property (@(posedge clk) disable iff (!rstN)
    (state == EP_IDLE) |=> (state != EP_ACT));
  // R4: retire only follows the armed state
  a_r4_retire_from_act: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retire) |-> ($past(state) == EP_ACT));
  // R10: cancel leaves idle with no retire
  a_r10_cancel_clears: assert property (@(posedge clk) disable iff (!rstN)
    cancelReq |=> (state == EP_IDLE && !busy && !retire));
  // R9: error flag only together with acknowledge
  a_r9_err_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    multErr |-> primeAck);
endmodule

// File: rtl/iso_sched_dp.sv
module iso_sched_dp
  import iso_sched_pkg::*;
#(
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [MULT_W-1:0] primeMult,
  output logic              lastXfer,
  output logic [MULT_W-1:0] frameCount,
  output logic [MULT_W-1:0] curMult,
  output logic              respValid,
  output logic [1:0]        respCode
);
  localparam int CW = MULT_W + 1;
  rspCode_t rspReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMult    <= '0;
      frameCount <= '0;
      respValid  <= 1'b0;
      rspReg     <= RSP_NONE;
    end else begin
      if (strobes.loadMult) curMult <= primeMult;
      if (strobes.clrCount) frameCount <= '0;
      else if (strobes.incCount) frameCount <= frameCount + 1'b1;
      respValid <= strobes.rspLoad;
      if (strobes.rspLoad) rspReg <= strobes.rspCode;
    end
  end

  assign lastXfer = ({1'b0, frameCount} + CW'(1)) == {1'b0, curMult};
  assign respCode = rspReg;

  // R5/R6: a loaded response always carries a real code
  a_r6_code_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respCode != 2'd0));
endmodule

// File: rtl/iso_ep_sched.sv
module iso_ep_sched
  import iso_sched_pkg::*;
#(
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              primeReq,
  input  logic [MULT_W-1:0] primeMult,
  input  logic              cancelReq,
  input  logic              sofStb,
  input  logic              tokValid,
  input  logic              tokIsIn,
  input  logic              xferDone,
  output logic              primeAck,
  output logic              multErr,
  output logic              retire,
  output logic              epPending,
  output logic              epArmed,
  output logic              respValid,
  output logic [1:0]        respCode
);
  dpCtrl_t           strobes;
  logic              lastXfer;
  logic [MULT_W-1:0] frameCount, curMult;

  iso_sched_ctrl #(.MULT_W(MULT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .primeReq(primeReq), .primeMult(primeMult),
    .cancelReq(cancelReq), .sofStb(sofStb), .tokValid(tokValid), .tokIsIn(tokIsIn),
    .xferDone(xferDone), .lastXfer(lastXfer), .strobes(strobes), .primeAck(primeAck),
    .multErr(multErr), .retire(retire), .epPending(epPending), .epArmed(epArmed));

  iso_sched_dp #(.MULT_W(MULT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .primeMult(primeMult),
    .lastXfer(lastXfer), .frameCount(frameCount), .curMult(curMult),
    .respValid(respValid), .respCode(respCode));

  // R3: frame count stays below the programmed count while armed
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    epArmed |-> (frameCount < curMult));
endmodule

// File: tb/iso_ep_sched_tb_top.sv
module iso_ep_sched_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic primeReq = 0, cancelReq = 0, sofStb = 0, tokValid = 0, tokIsIn = 0, xferDone = 0;
  logic [1:0] primeMult = 2'd0;
  logic primeAck, multErr, retire, epPending, epArmed, respValid;
  logic [1:0] respCode;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural model state: 0 idle, 1 pending, 2 armed
  int mSt = 0, mBusy = 0, mLat = 0, mCnt = 0, mMult = 0;
  int eAck = 0, eErr = 0, eRet = 0, eRv = 0, eRc = 0;

  always #4 clk = ~clk;

  iso_ep_sched dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mSt = 0; mBusy = 0; mLat = 0; mCnt = 0; mMult = 0;
      eAck = 0; eErr = 0; eRet = 0; eRv = 0;
    end else begin
      eAck = 0; eErr = 0; eRet = 0; eRv = 0;
      if (tokValid) begin
        eRv = 1;
        if (mSt == 2 && !cancelReq) eRc = mBusy ? 3 : 2;
        else eRc = tokIsIn ? 1 : 3;
      end
      if (cancelReq) begin
        mSt = 0; mBusy = 0; mLat = 0;
      end else if (mSt == 0) begin
        if (primeReq) begin
          eAck = 1;
          if (primeMult == 0) eErr = 1;
          else begin mSt = 1; mMult = primeMult; end
        end
      end else if (mSt == 1) begin
        if (sofStb) begin mSt = 2; mCnt = 0; end
      end else begin
        if (mBusy != 0) begin
          if (xferDone) begin
            mBusy = 0;
            if (mCnt + 1 == mMult) begin eRet = 1; mSt = 0; mLat = 0; end
            else if (mLat != 0 || sofStb) begin mCnt = 0; mLat = 0; end
            else mCnt++;
          end else if (sofStb) mLat = 1;
        end else begin
          if (sofStb) mCnt = 0;
          if (tokValid) mBusy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 primeAck", primeAck, eAck);
      chk("R9 multErr", multErr, eErr);
      chk("R4 retire", retire, eRet);
      chk("R1 epPending", epPending, mSt == 1);
      chk("R7 epArmed", epArmed, mSt == 2);
      chk("R5 respValid", respValid, eRv);
      if (eRv != 0) chk(eRc == 1 ? "R5 respCode" : "R6 R8 respCode", respCode, eRc);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic clearIn();
    primeReq = 0; cancelReq = 0; sofStb = 0; tokValid = 0; xferDone = 0;
  endtask
  task automatic prime(int m);
    @(negedge clk); primeReq = 1; primeMult = 2'(m);
    @(negedge clk); clearIn();
  endtask
  task automatic sof();
    @(negedge clk); sofStb = 1; @(negedge clk); clearIn();
  endtask
  task automatic tok(bit isIn);
    @(negedge clk); tokValid = 1; tokIsIn = isIn; @(negedge clk); clearIn();
  endtask
  task automatic xdone();
    @(negedge clk); xferDone = 1; @(negedge clk); clearIn();
  endtask

  initial begin
    step(3);
    // reset state
    chk("R1 reset pending", epPending, 0);
    chk("R7 reset armed", epArmed, 0);
    chk("R5 reset respValid", respValid, 0);
    @(negedge clk); rstN = 1;
    step(1);
    // R5 / R6 unprimed tokens
    tok(1); chk("R5 zlp code", respCode, 1);
    tok(0); chk("R6 drop code", respCode, 3);
    // R1 / R2 / R12 prime held until SOF
    prime(2);
    chk("R2 ack", primeAck, 1);
    chk("R1 pending", epPending, 1);
    chk("R1 not armed", epArmed, 0);
    tok(1); chk("R5 zlp while pending", respCode, 1);
    prime(1); chk("R12 no ack", primeAck, 0);
    sof(); chk("R1 armed after sof", epArmed, 1);
    // R3 / R4 two transactions then retire
    tok(1); chk("R6 xfer code", respCode, 2);
    xdone(); tok(0); xdone();
    chk("R4 retire pulse", retire, 1);
    step(1); chk("R4 idle after", epArmed, 0);
    // R7 / R8 frame restart with busy collisions
    prime(3); sof();
    tok(1); xdone();
    sof(); chk("R7 still armed", epArmed, 1);
    tok(1); tok(1); chk("R8 busy drop", respCode, 3);
    xdone(); tok(1); xdone(); tok(1); xdone();
    chk("R3 retire after 3", retire, 1);
    // R11 SOF held across busy transaction
    prime(2); sof(); tok(0); sof(); xdone();
    chk("R11 no retire", retire, 0);
    tok(0); xdone(); chk("R11 still armed", epArmed, 1);
    tok(0); xdone(); chk("R11 retire", retire, 1);
    // R9 zero count
    prime(0); chk("R9 err", multErr, 1);
    step(1); chk("R9 idle", epPending, 0);
    // R10 cancel with simultaneous done
    prime(1); sof(); tok(1);
    @(negedge clk); cancelReq = 1; xferDone = 1;
    @(negedge clk); clearIn();
    chk("R10 no retire", retire, 0);
    chk("R10 idle", epArmed, 0);
    tok(1); chk("R10 zlp after cancel", respCode, 1);
    // R10 cancel while pending
    prime(3); @(negedge clk); cancelReq = 1; sofStb = 1;
    @(negedge clk); clearIn();
    chk("R10 pending cleared", epPending, 0);
    chk("R10 not armed", epArmed, 0);
    step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule